// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This block multiplies two 18-bit operands and folds the 36-bit product into a 52-bit running total, adding or subtracting it as chosen in each cycle. Each operand carries its own two's-complement/unsigned select, so signed, unsigned and mixed products are all formed exactly. A load control makes the accumulator take the incoming product in place of its total. A new accumulation can therefore start in the cycle right after the previous one ends. A sticky flag reports when the exact result of an accumulate step falls outside the 52-bit range, up or down.

The datapath has three register stages: operand registers, a product register and the accumulator. The select and add/subtract controls travel alongside their operands. The load control passes through `LOAD_STAGES` registers (0, 1 or 2) before it reaches the accumulator. It must be driven `2 - LOAD_STAGES` cycles after the operands whose product it loads. Every register shares one clock, one clock enable (`ena`) and one asynchronous active-high clear (`clr`).

The block has no valid/ready handshake. Flow control is the clock enable: while `ena` is low, nothing moves and every register holds its value. Each operand register can take its value from a shift-in port instead of the parallel input, and it always drives a shift-out port. Several units can therefore be chained into a delay line. Narrower operands are handled by zero-filling their low-order bits, which scales the result by a power of two.

Top module: `mac_unit`

## Requirements
- R1: A high `clr` drives `acc_out`, `ovf`, `a_shout` and `b_shout` to zero at once, without waiting for a clock edge.
- R2: The product is the exact product of the captured operands. Each operand is read as two's complement when its select input is 1 and as unsigned when it is 0. The product is sign-extended into the 52-bit accumulator when either select is 1, and zero-extended when both are 0.
- R3: In signed mode (either select 1), `ovf` rises when the exact result of a step lies outside -2^51..2^51-1. In unsigned mode, it rises when the result lies outside 0..2^52-1. Once set, it stays set until a load step or `clr`.
- R4: A step with load 0 and `sub` 0 adds the product to the total, and a step with `sub` 1 subtracts it. The stored result is the exact result modulo 2^52.
- R5: A step with load 1 stores the extended product as the new total and clears `ovf`. The following step accumulates onto that value with no idle cycle.
- R6: With the default `LOAD_STAGES`=2, operands and controls driven before clock edge n show their effect on `acc_out` and `ovf` after edge n+2. The load control is driven in the same cycle as its operands.
- R7: While `ena` is 0, every register holds its value, whatever the data and control inputs do.
- R8: When a chain select is 1, the operand register captures its shift-in port instead of its parallel input. The shift-out port always shows the operand register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| clr | input | 1 | Asynchronous clear, active high |
| ena | input | 1 | Clock enable for every register |
| a_in | input | 18 | Operand A parallel input |
| b_in | input | 18 | Operand B parallel input |
| a_shin | input | 18 | Operand A shift-in |
| b_shin | input | 18 | Operand B shift-in |
| a_chain | input | 1 | 1: operand A register loads from a_shin |
| b_chain | input | 1 | 1: operand B register loads from b_shin |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_signed | input | 1 | 1: operand B is two's complement |
| sub | input | 1 | 1: subtract the product, 0: add it |
| load | input | 1 | 1: replace the total with the product |
| a_shout | output | 18 | Operand A register contents |
| b_shout | output | 18 | Operand B register contents |
| acc_out | output | 52 | Accumulated total |
| ovf | output | 1 | Sticky overflow/underflow flag |

## Verification
A fault in an operand register appears on its shift-out port one edge after capture and in the total two edges later. A wrong product or a misaligned control corrupts `acc_out` at the accumulate step. Because the total is the stored state, a wrong value persists in every later output until a load or a clear replaces it. A wrong overflow decision stays visible on the sticky `ovf` until the next load, so a single check after a flush exposes it. The long unsigned run that ends in a signed crossing exercises the bit-51 boundary, where a wrong range rule would show.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // controls that travel with an operand pair
  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic sub;
  } mac_ctl_t;

  localparam int CTL_W = $bits(mac_ctl_t);
endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= '0;
    else if (ena) q <= d;
  end
endmodule

// File: rtl/mac_opnd_reg.sv
module mac_opnd_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ena,
  input  logic [W-1:0] par_in,
  input  logic [W-1:0] chain_in,
  input  logic         chain_sel,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;
  assign nxt = chain_sel ? chain_in : par_in;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= '0;
    else if (ena) q <= nxt;
  end
endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
  import mac_pkg::*;
#(
  parameter int A_W = 18,
  parameter int B_W = 18,
  localparam int P_W = A_W + B_W,
  localparam int X_W = P_W + 2
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           ena,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  mac_ctl_t       ctl,
  output logic [P_W-1:0] prod_q,
  output logic           psgn_q,
  output logic           sub_q
);
  logic signed [X_W-1:0] a_x;
  logic signed [X_W-1:0] b_x;
  logic signed [X_W-1:0] full;

  // extend each operand by its own signedness, then multiply signed
  assign a_x  = signed'({{(X_W-A_W){ctl.a_sgn & a[A_W-1]}}, a});
  assign b_x  = signed'({{(X_W-B_W){ctl.b_sgn & b[B_W-1]}}, b});
  assign full = a_x * b_x;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      prod_q <= '0;
      psgn_q <= 1'b0;
      sub_q  <= 1'b0;
    end else if (ena) begin
      prod_q <= full[P_W-1:0];
      psgn_q <= ctl.a_sgn | ctl.b_sgn;
      sub_q  <= ctl.sub;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int P_W   = 36,
  parameter int ACC_W = 52,
  localparam int G_W  = ACC_W - P_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ena,
  input  logic [P_W-1:0]   prod,
  input  logic             psgn,
  input  logic             sub,
  input  logic             load,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf_q
);
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] addend;
  logic [ACC_W:0]   sum_full;
  logic [ACC_W-1:0] res;
  logic             old_s, ext_s, res_s;
  logic             ovf_sgn, ovf_uns, step_ovf;

  assign ext      = {{G_W{psgn & prod[P_W-1]}}, prod};
  assign addend   = sub ? ~ext : ext;
  assign sum_full = {1'b0, acc_q} + {1'b0, addend} + {{ACC_W{1'b0}}, sub};
  assign res      = sum_full[ACC_W-1:0];

  assign old_s = acc_q[ACC_W-1];
  assign ext_s = ext[ACC_W-1];
  assign res_s = res[ACC_W-1];

  // signed: operands agree (add) or differ (subtract) and result sign flips
  assign ovf_sgn  = (sub ? (old_s != ext_s) : (old_s == ext_s)) && (res_s != old_s);
  // unsigned: carry out on add, no carry (borrow) on subtract
  assign ovf_uns  = sub ? ~sum_full[ACC_W] : sum_full[ACC_W];
  assign step_ovf = psgn ? ovf_sgn : ovf_uns;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ena) begin
      if (load) begin
        acc_q <= ext;
        ovf_q <= 1'b0;
      end else begin
        acc_q <= res;
        ovf_q <= ovf_q | step_ovf;
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int A_W         = 18,
  parameter int B_W         = 18,
  parameter int GUARD_W     = 16,
  parameter int LOAD_STAGES = 2,
  localparam int P_W        = A_W + B_W,
  localparam int ACC_W      = P_W + GUARD_W
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ena,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [A_W-1:0]   a_shin,
  input  logic [B_W-1:0]   b_shin,
  input  logic             a_chain,
  input  logic             b_chain,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             sub,
  input  logic             load,
  output logic [A_W-1:0]   a_shout,
  output logic [B_W-1:0]   b_shout,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  generate
    if (LOAD_STAGES < 0 || LOAD_STAGES > 2) begin : g_bad_param
      $error("LOAD_STAGES must be 0, 1 or 2");
    end
  endgenerate

  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  mac_ctl_t         ctl_in, ctl_q;
  logic [P_W-1:0]   prod_q;
  logic             prod_sgn;
  logic             sub_al;
  logic             load_al;
  logic [LOAD_STAGES:0] ld_pipe;

  // stage 1: operand and control registers
  mac_opnd_reg #(.W(A_W)) u_a_reg (
    .clk(clk), .clr(clr), .ena(ena), .par_in(a_in), .chain_in(a_shin),
    .chain_sel(a_chain), .q(a_q)
  );

  mac_opnd_reg #(.W(B_W)) u_b_reg (
    .clk(clk), .clr(clr), .ena(ena), .par_in(b_in), .chain_in(b_shin),
    .chain_sel(b_chain), .q(b_q)
  );

  assign ctl_in = '{a_sgn: a_signed, b_sgn: b_signed, sub: sub};

  mac_pipe_reg #(.W(CTL_W)) u_ctl_reg (
    .clk(clk), .clr(clr), .ena(ena), .d(ctl_in), .q(ctl_q)
  );

  assign a_shout = a_q;
  assign b_shout = b_q;

  // stage 2: product register, controls follow
  mac_mult_stage #(.A_W(A_W), .B_W(B_W)) u_mult (
    .clk(clk), .clr(clr), .ena(ena), .a(a_q), .b(b_q), .ctl(ctl_q),
    .prod_q(prod_q), .psgn_q(prod_sgn), .sub_q(sub_al)
  );

  // load control delay line, depth chosen at compile time
  assign ld_pipe[0] = load;
  generate
    for (genvar i = 0; i < LOAD_STAGES; i++) begin : g_ld
      mac_pipe_reg #(.W(1)) u_ld (
        .clk(clk), .clr(clr), .ena(ena), .d(ld_pipe[i]), .q(ld_pipe[i+1])
      );
    end
  endgenerate
  assign load_al = ld_pipe[LOAD_STAGES];

  // stage 3: accumulator and overflow flag
  mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .clr(clr), .ena(ena), .prod(prod_q), .psgn(prod_sgn),
    .sub(sub_al), .load(load_al), .acc_q(acc_out), .ovf_q(ovf)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int A_W   = 18,
  parameter int P_W   = 36,
  parameter int ACC_W = 52,
  localparam int G_W  = ACC_W - P_W
) (
  input logic             clk,
  input logic             clr,
  input logic             ena,
  input logic             a_chain,
  input logic [A_W-1:0]   a_shin,
  input logic [A_W-1:0]   a_shout,
  input logic [P_W-1:0]   prod_q,
  input logic             prod_sgn,
  input logic             sub_al,
  input logic             load_al,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf
);
  logic [ACC_W-1:0] want_ext;
  assign want_ext = prod_sgn ? {{G_W{prod_q[P_W-1]}}, prod_q} : {{G_W{1'b0}}, prod_q};

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (clr)
    !ena |=> $stable(acc_out) && $stable(ovf) && $stable(a_shout));

  assert_load_takes_product_R5: assert property (@(posedge clk) disable iff (clr)
    ena && load_al |=> acc_out == $past(want_ext) && !ovf);

  assert_add_step_R4: assert property (@(posedge clk) disable iff (clr)
    ena && !load_al && !sub_al |=> acc_out == ($past(acc_out) + $past(want_ext)));

  assert_sticky_flag_R3: assert property (@(posedge clk) disable iff (clr)
    ena && !load_al && ovf |=> ovf);

  assert_chain_capture_R8: assert property (@(posedge clk) disable iff (clr)
    ena && a_chain |=> a_shout == $past(a_shin));
endmodule

bind mac_unit mac_unit_chk #(.A_W(A_W), .P_W(P_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .clr(clr), .ena(ena), .a_chain(a_chain), .a_shin(a_shin),
  .a_shout(a_shout), .prod_q(prod_q), .prod_sgn(prod_sgn), .sub_al(sub_al),
  .load_al(load_al), .acc_out(acc_out), .ovf(ovf)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        ena = 1'b1;
  logic [17:0] a_in = '0, b_in = '0, a_shin = '0, b_shin = '0;
  logic        a_chain = 0, b_chain = 0, a_signed = 0, b_signed = 0, sub = 0, load = 0;
  logic [17:0] a_shout, b_shout;
  logic [51:0] acc_out;
  logic        ovf;

  int checks = 0;
  int errors = 0;

  // bench model state, computed from the requirements
  logic [51:0] exp_acc = '0;
  bit          exp_ovf = 0;

  always #4 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .clr(clr), .ena(ena), .a_in(a_in), .b_in(b_in), .a_shin(a_shin),
    .b_shin(b_shin), .a_chain(a_chain), .b_chain(b_chain), .a_signed(a_signed),
    .b_signed(b_signed), .sub(sub), .load(load), .a_shout(a_shout),
    .b_shout(b_shout), .acc_out(acc_out), .ovf(ovf)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic longint prod_of(input logic [17:0] a, input logic [17:0] b, input bit as, input bit bs);
    longint pa, pb;
    pa = as ? longint'($signed(a)) : longint'({46'b0, a});
    pb = bs ? longint'($signed(b)) : longint'({46'b0, b});
    return pa * pb;
  endfunction

  // R2 R3 R4 R5 arithmetic model
  task automatic model(input logic [17:0] a, input logic [17:0] b, input bit as, input bit bs, input bit sb, input bit ld);
    longint p, old, tru, lo, hi;
    logic [63:0] t;
    p = prod_of(a, b, as, bs);
    if (ld) begin
      t = p;
      exp_acc = t[51:0];
      exp_ovf = 0;
    end else begin
      if (as || bs) begin
        old = longint'($signed(exp_acc));
        lo = -(longint'(1) <<< 51);
        hi = (longint'(1) <<< 51) - 1;
      end else begin
        old = longint'({12'b0, exp_acc});
        lo = 0;
        hi = (longint'(1) <<< 52) - 1;
      end
      tru = sb ? old - p : old + p;
      if (tru < lo || tru > hi) exp_ovf = 1;
      t = tru;
      exp_acc = t[51:0];
    end
  endtask

  task automatic drive(input logic [17:0] a, input logic [17:0] b, input bit as, input bit bs, input bit sb, input bit ld);
    a_in = a; b_in = b; a_signed = as; b_signed = bs; sub = sb; load = ld;
    a_chain = 0; b_chain = 0;
  endtask

  task automatic op(input logic [17:0] a, input logic [17:0] b, input bit as, input bit bs, input bit sb, input bit ld);
    drive(a, b, as, bs, sb, ld);
    model(a, b, as, bs, sb, ld);
    @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) op(18'd0, 18'd0, 0, 0, 0, 0);
  endtask

  task automatic check_state(input string tag);
    check(acc_out === exp_acc, {tag, " acc"}, {12'b0, acc_out}, {12'b0, exp_acc});
    check(ovf === exp_ovf, {tag, " ovf"}, {63'b0, ovf}, {63'b0, exp_ovf});
  endtask

  task automatic t_reset();
    check(acc_out === '0 && ovf === 1'b0, "R1 reset acc/ovf", {11'b0, ovf, acc_out}, 64'd0);
    check(a_shout === '0 && b_shout === '0, "R1 reset shout", {28'b0, a_shout, b_shout}, 64'd0);
  endtask

  task automatic t_signed_mix();
    op(18'd3, 18'h3FFFB, 1, 1, 0, 1);   // load 3 * -5
    op(18'd7, 18'd9, 1, 1, 0, 0);       // add 63
    op(18'd2, 18'd4, 1, 1, 1, 0);       // subtract 8
    flush();
    check_state("R4 add/sub signed sequence");
    check(acc_out === 52'd40, "R4 value 40", {12'b0, acc_out}, 64'd40);
  endtask

  task automatic t_unsigned_max();
    op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1);
    flush();
    check_state("R2 unsigned max product");
  endtask

  task automatic t_mixed_sign();
    op(18'h3FFFF, 18'd2, 1, 0, 0, 1);   // -1 (signed) * 2 (unsigned)
    flush();
    check_state("R2 mixed signedness");
    op(18'h20000, 18'h3FFFF, 1, 0, 0, 1); // -2^17 * (2^18-1)
    flush();
    check_state("R2 mixed extreme");
  endtask

  // R5 R6: back-to-back load, observed each cycle
  task automatic t_no_bubble();
    logic [51:0] want [4];
    logic [17:0] av [4];
    logic [17:0] bv [4];
    bit          lv [4];
    av = '{18'd3, 18'd5, 18'h3FFF9, 18'd10};
    bv = '{18'd4, 18'd6, 18'd3, 18'd10};
    lv = '{1'b1, 1'b0, 1'b1, 1'b0};
    want = '{52'd12, 52'd42, 52'hF_FFFF_FFFF_FFEB, 52'd79};
    drive(av[0], bv[0], 1, 1, 0, lv[0]);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (n >= 3) check(acc_out === want[n-3], "R6 R5 per-cycle total", {12'b0, acc_out}, {12'b0, want[n-3]});
      if (n < 4) drive(av[n], bv[n], 1, 1, 0, lv[n]);
      else drive(18'd0, 18'd0, 0, 0, 0, 0);
    end
    exp_acc = 52'd79;
    exp_ovf = 0;
    flush();
    check_state("R5 after restart");
  endtask

  task automatic t_unsigned_borrow();
    op(18'd0, 18'd0, 0, 0, 0, 1);
    op(18'd1, 18'd1, 0, 0, 1, 0);
    flush();
    check_state("R3 unsigned underflow");
    check(ovf === 1'b1, "R3 borrow flag", {63'b0, ovf}, 64'd1);
    op(18'd5, 18'd1, 0, 0, 0, 1);
    flush();
    check_state("R5 load clears flag");
  endtask

  task automatic t_signed_overflow();
    longint p, lim;
    p = prod_of(18'h3FFFF, 18'h3FFFF, 0, 0);
    lim = longint'(1) <<< 51;
    op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1);
    while (longint'({12'b0, exp_acc}) + p < lim) op(18'h3FFFF, 18'h3FFFF, 0, 0, 0, 0);
    flush();
    check_state("R3 unsigned run below bit 51");
    while (!exp_ovf) op(18'h20000, 18'h20000, 1, 1, 0, 0);
    flush();
    check_state("R3 signed crossing of 2^51");
    op(18'd1, 18'd1, 1, 1, 0, 0);
    flush();
    check_state("R3 flag stays set");
  endtask

  task automatic t_async_clear();
    #2;
    clr = 1'b1;
    #1;
    check(acc_out === '0 && ovf === 1'b0, "R1 async clear mid-cycle", {11'b0, ovf, acc_out}, 64'd0);
    exp_acc = '0;
    exp_ovf = 0;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check_state("R1 after clear");
  endtask

  task automatic t_stall();
    logic [51:0] held;
    op(18'd11, 18'd13, 0, 0, 0, 1);
    flush();
    held = acc_out;
    ena = 1'b0;
    for (int i = 0; i < 5; i++) begin
      a_in = 18'd123 + 18'(i); b_in = 18'd45; load = 1'b1; sub = 1'b1;
      a_chain = 1'b1; a_shin = 18'h155;
      @(negedge clk);
    end
    check(acc_out === held && ovf === 1'b0, "R7 total held while stalled", {12'b0, acc_out}, {12'b0, held});
    check(a_shout === '0, "R7 operand register held", {46'b0, a_shout}, 64'd0);
    drive(18'd0, 18'd0, 0, 0, 0, 0);
    ena = 1'b1;
    flush();
    check_state("R7 resume without side effect");
  endtask

  task automatic t_chain();
    a_in = 18'd999; b_in = 18'd1; a_shin = 18'd7; b_shin = 18'h3FFFE;
    a_chain = 1; b_chain = 1; a_signed = 1; b_signed = 1; sub = 0; load = 1;
    model(18'd7, 18'h3FFFE, 1, 1, 0, 1);
    @(negedge clk);
    check(a_shout === 18'd7, "R8 a shift-out", {46'b0, a_shout}, 64'd7);
    check(b_shout === 18'h3FFFE, "R8 b shift-out", {46'b0, b_shout}, 64'h3FFFE);
    flush();
    check_state("R8 product from chained operands");
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    clr = 1'b0;
    @(negedge clk);
    t_signed_mix();
    t_unsigned_max();
    t_mixed_sign();
    t_no_bubble();
    t_unsigned_borrow();
    t_chain();
    t_stall();
    t_signed_overflow();
    t_async_clear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule